// File: doc/BRIEF.md
# System Global Control Register File

This block is a bank of 32-bit control and status words behind a zero-wait APB3 slave port that decodes 4 KiB of address space. Each word has a fixed write policy: plain read/write, read-only, write-1-to-clear, or write-1-to-set. Software uses the bank to read identity and strap information, to record sticky status, and to set lock and module-disable bits that only a reset can take back.

At reset most words load constants. Three words instead take their reset value from inputs: the power-on strap word, the module-disable word, and a memory configuration word. The memory configuration word carries a size code computed from a DRAM-size input, given as log2 of the size in bytes. A size outside the supported range raises a configuration error and forces the code to zero.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is `paddr[11:2]`. A transfer completes in its access phase, `pready` is always 1, and read data is valid in that phase. Any access with `paddr[1:0]` not zero raises `pslverr` and its write is dropped, but a read still returns the word at that index.
- R2: Indices 82 and above (byte offset 0x148 and up) read as zero, ignore writes, and raise `pslverr`.
- R3: The words at offsets 0x00, 0x04 and 0x40 are read-only. A write to one of them leaves its value unchanged and raises `pslverr`.
- R4: Offsets 0x6C and 0xD4 are write-1-to-clear: the new value is `old & ~pwdata`.
- R5: Offsets 0x70 and 0x7C are write-1-to-set: the new value is `old | pwdata`, so a bit never returns to 0 without a reset.
- R6: Every other in-range word stores a full write as given and reads it back.
- R7: Reset loads these constants: 0x00=04A92750, 0x10=0000FFFF, 0x38=00000003, 0x3C=0000035E, 0x50=0000004E, 0x60=00080000, 0x6C=80000000, 0x78=000000C0, 0x98=5A00F3CF, 0x13C=00000008, 0x140=0x144=034730E4. All others reset to 0, apart from those named in R8 and R9.
- R8: Reset loads offset 0x04 from `strap_pwron` and offset 0x7C from `cfg_mod_disable`.
- R9: Reset loads offset 0x9C with 0x00001002 OR (code << 8), where code = `dram_size_log2` − 27 for inputs 27 to 31 (128 MiB to 2 GiB).
- R10: For any `dram_size_log2` outside 27 to 31, `config_error` is 1 and the code in R9 is 0. Inside that range, `config_error` is 0.
- R11: A write whose `pstrb` is not 4'hF is dropped and raises no `pslverr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; only 4'hF writes |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response |
| strap_pwron | input | 32 | Reset value of the strap word |
| cfg_mod_disable | input | 32 | Reset value of the module-disable word |
| dram_size_log2 | input | 5 | log2 of DRAM size in bytes |
| config_error | output | 1 | DRAM size unsupported |

## Verification
Two functions can act on the same transfer: the per-word write policy and the error response. The bench provokes this by writing to read-only words, out-of-range offsets, misaligned addresses and partial strobes. For each case it checks in the access phase whether `pslverr` is set, and then reads the target word or the whole bank back to confirm whether the write took effect. Each reset in a sweep of all 32 size inputs checks the reset loading and the size code together.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} pol_e;

   localparam int IDX_STRAP   = 1;
   localparam int IDX_MODDIS  = 31;
   localparam int IDX_MEMCFG  = 39;

   function automatic pol_e slot_policy(input int idx);
      case (idx)
         0, 1, 16: return POL_RO;
         27, 53:   return POL_W1C;
         28, 31:   return POL_W1S;
         default:  return POL_RW;
      endcase
   endfunction

   function automatic logic [31:0] fixed_reset(input int idx);
      case (idx)
         0:       return 32'h04A9_2750;
         4:       return 32'h0000_FFFF;
         14:      return 32'h0000_0003;
         15:      return 32'h0000_035E;
         20:      return 32'h0000_004E;
         24:      return 32'h0008_0000;
         27:      return 32'h8000_0000;
         30:      return 32'h0000_00C0;
         38:      return 32'h5A00_F3CF;
         79:      return 32'h0000_0008;
         80, 81:  return 32'h0347_30E4;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_dram_code.sv
module sysctl_dram_code #(
   parameter int LOG2_W   = 5,
   parameter int MIN_LOG2 = 27,
   parameter int MAX_LOG2 = 31,
   localparam int CODE_W  = $clog2(MAX_LOG2 - MIN_LOG2 + 1)
) (
   input  logic [LOG2_W-1:0] size_log2,
   output logic [CODE_W-1:0] code,
   output logic              bad_size
);

   if (MAX_LOG2 < MIN_LOG2) begin : g_bad_range
      $error("sysctl_dram_code: MAX_LOG2 below MIN_LOG2");
   end
   if (MAX_LOG2 >= (1 << LOG2_W)) begin : g_bad_width
      $error("sysctl_dram_code: LOG2_W too narrow");
   end

   logic [LOG2_W-1:0] offs;

   always_comb begin
      bad_size = (int'(size_log2) < MIN_LOG2) || (int'(size_log2) > MAX_LOG2);
      offs     = size_log2 - LOG2_W'(MIN_LOG2);
      code     = bad_size ? '0 : offs[CODE_W-1:0];
   end

endmodule

// File: rtl/sysctl_reg_slot.sv
module sysctl_reg_slot #(
   parameter int                DATA_W = 32,
   parameter sysctl_pkg::pol_e  POLICY = sysctl_pkg::POL_RW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rst_val,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] nxt;

   always_comb begin
      case (POLICY)
         sysctl_pkg::POL_RO:  nxt = q;
         sysctl_pkg::POL_W1C: nxt = q & ~wdata;
         sysctl_pkg::POL_W1S: nxt = q | wdata;
         default:             nxt = wdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= rst_val;
      else if (wr_en) q <= nxt;
   end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 82,
   parameter int LOG2_W   = 5,
   parameter int MIN_LOG2 = 27,
   parameter int MAX_LOG2 = 31,
   localparam int STRB_W  = DATA_W / 8
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [STRB_W-1:0] pstrb,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [DATA_W-1:0] strap_pwron,
   input  logic [DATA_W-1:0] cfg_mod_disable,
   input  logic [LOG2_W-1:0] dram_size_log2,
   output logic              config_error
);

   localparam int IDX_W  = ADDR_W - 2;
   localparam int CODE_W = $clog2(MAX_LOG2 - MIN_LOG2 + 1);

   if (DATA_W != 32) begin : g_bad_data
      $error("sysctl_regbank: DATA_W must be 32");
   end
   if (NUM_REGS * 4 > (1 << ADDR_W)) begin : g_bad_depth
      $error("sysctl_regbank: NUM_REGS exceeds address window");
   end

   logic [IDX_W-1:0]  idx;
   logic              access, aligned, full_word, in_range, wr_ok;
   logic [NUM_REGS-1:0] ro_sel;
   logic [DATA_W-1:0] reg_q [NUM_REGS];
   logic [CODE_W-1:0] size_code;

   sysctl_dram_code #(
      .LOG2_W(LOG2_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
   ) size_i (
      .size_log2(dram_size_log2),
      .code     (size_code),
      .bad_size (config_error)
   );

   always_comb begin
      idx       = paddr[ADDR_W-1:2];
      access    = psel & penable;
      aligned   = (paddr[1:0] == 2'b00);
      full_word = &pstrb;
      in_range  = int'(idx) < NUM_REGS;
      wr_ok     = access & pwrite & in_range & aligned & full_word;
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam sysctl_pkg::pol_e POL = sysctl_pkg::slot_policy(i);
      logic [DATA_W-1:0] rst_val;

      if (i == sysctl_pkg::IDX_STRAP) begin : g_rst_strap
         assign rst_val = strap_pwron;
      end else if (i == sysctl_pkg::IDX_MODDIS) begin : g_rst_moddis
         assign rst_val = cfg_mod_disable;
      end else if (i == sysctl_pkg::IDX_MEMCFG) begin : g_rst_memcfg
         assign rst_val = DATA_W'(32'h0000_1002) | (DATA_W'(size_code) << 8);
      end else begin : g_rst_const
         assign rst_val = DATA_W'(sysctl_pkg::fixed_reset(i));
      end

      assign ro_sel[i] = (POL == sysctl_pkg::POL_RO) && (int'(idx) == i);

      sysctl_reg_slot #(.DATA_W(DATA_W), .POLICY(POL)) slot_i (
         .clk    (pclk),
         .rst_n  (presetn),
         .rst_val(rst_val),
         .wr_en  (wr_ok && (int'(idx) == i)),
         .wdata  (pwdata),
         .q      (reg_q[i])
      );
   end

   always_comb begin
      prdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(idx) == i) prdata = reg_q[i];
      end
      pready  = 1'b1;
      pslverr = access & (~in_range | ~aligned | (pwrite & (|ro_sel)));
   end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 82
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [3:0]        pstrb,
   input logic [DATA_W-1:0] prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [DATA_W-1:0] reg_q [NUM_REGS]
);

   logic acc;
   logic oor;
   assign acc = psel & penable;
   assign oor = int'(paddr[ADDR_W-1:2]) >= NUM_REGS;

   // R1
   ready_high_chk: assert property (@(posedge pclk) disable iff (!presetn)
      pready);

   // R2
   oor_read_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !pwrite && oor) |-> (prdata == '0 && pslverr));

   // R3
   ro_id_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && paddr == ADDR_W'(12'h000)) |=> $stable(reg_q[0]));

   // R3
   ro_strap_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && paddr == ADDR_W'(12'h004)) |=> $stable(reg_q[1]));

   // R3
   ro_write_err_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && paddr == ADDR_W'(12'h040)) |-> pslverr);

   // R4
   w1c_no_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
      1'b1 |=> ((reg_q[27] & ~$past(reg_q[27])) == '0));

   // R5
   w1s_no_clear_chk: assert property (@(posedge pclk) disable iff (!presetn)
      1'b1 |=> ((reg_q[31] & $past(reg_q[31])) == $past(reg_q[31])));

   // R11
   strobe_drop_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && pstrb != 4'hF && paddr == ADDR_W'(12'h010))
      |=> $stable(reg_q[4]));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) chk_i (
   .pclk   (pclk),
   .presetn(presetn),
   .psel   (psel),
   .penable(penable),
   .pwrite (pwrite),
   .paddr  (paddr),
   .pstrb  (pstrb),
   .prdata (prdata),
   .pready (pready),
   .pslverr(pslverr),
   .reg_q  (reg_q)
);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NREG = 82;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [3:0]  pstrb = 4'hF;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [31:0] strap_pwron = 32'hDEAD_0F01;
   logic [31:0] cfg_mod_disable = 32'h0000_0240;
   logic [4:0]  dram_size_log2 = 5'd29;
   logic        config_error;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] model [NREG];

   always #(CLK_PERIOD/2) pclk = ~pclk;

   sysctl_regbank dut_i (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
      .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .strap_pwron(strap_pwron), .cfg_mod_disable(cfg_mod_disable),
      .dram_size_log2(dram_size_log2), .config_error(config_error)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // 0 = RW, 1 = RO, 2 = W1C, 3 = W1S
   function automatic int pol_of(input int i);
      if (i == 0 || i == 1 || i == 16) return 1;
      if (i == 27 || i == 53) return 2;
      if (i == 28 || i == 31) return 3;
      return 0;
   endfunction

   function automatic logic [31:0] rst_of(input int i, input logic [4:0] l2);
      case (i)
         0:  return 32'h04A9_2750;
         1:  return strap_pwron;
         4:  return 32'h0000_FFFF;
         14: return 32'h0000_0003;
         15: return 32'h0000_035E;
         20: return 32'h0000_004E;
         24: return 32'h0008_0000;
         27: return 32'h8000_0000;
         30: return 32'h0000_00C0;
         31: return cfg_mod_disable;
         38: return 32'h5A00_F3CF;
         39: return (l2 >= 27 && l2 <= 31) ? (32'h1002 | (32'(l2 - 5'd27) << 8)) : 32'h1002;
         79: return 32'h0000_0008;
         80, 81: return 32'h0347_30E4;
         default: return 32'h0;
      endcase
   endfunction

   task automatic do_reset(input logic [4:0] l2);
      @(negedge pclk);
      dram_size_log2 = l2;
      presetn = 1'b0;
      repeat (2) @(negedge pclk);
      presetn = 1'b1;
      for (int i = 0; i < NREG; i++) model[i] = rst_of(i, l2);
   endtask

   task automatic apb_read(input logic [11:0] a, output logic [31:0] d, output logic e);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata; e = pslverr;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic apb_write(input logic [11:0] a, input logic [31:0] d,
                            input logic [3:0] s, output logic e);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; pstrb = s;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      e = pslverr;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = 4'hF;
   endtask

   task automatic sweep_readback(input string req);
      logic [31:0] d;
      logic e;
      for (int i = 0; i < NREG; i++) begin
         apb_read(12'(i * 4), d, e);
         check(req, d, model[i]);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic e;
      logic [31:0] w;

      do_reset(5'd29);
      // R7 R8 R9: whole-bank reset image
      sweep_readback("R7/R8/R9 reset");
      check("R1 pready", 32'(pready), 32'h1);
      check("R10 config_error in range", 32'(config_error), 32'h0);

      // R3 R4 R5 R6: write every word, then read back
      for (int i = 0; i < NREG; i++) begin
         w = 32'h5A3C_96E1 ^ (32'(i) * 32'h0102_0408);
         apb_write(12'(i * 4), w, 4'hF, e);
         case (pol_of(i))
            1: begin check("R3 ro pslverr", 32'(e), 32'h1); end
            2: begin model[i] = model[i] & ~w; check("R4 w1c pslverr", 32'(e), 32'h0); end
            3: begin model[i] = model[i] | w;  check("R5 w1s pslverr", 32'(e), 32'h0); end
            default: begin model[i] = w; check("R6 rw pslverr", 32'(e), 32'h0); end
         endcase
         apb_read(12'(i * 4), d, e);
         check("R3/R4/R5/R6 readback", d, model[i]);
      end

      // R4: clear all bits
      apb_write(12'h06C, 32'hFFFF_FFFF, 4'hF, e);
      apb_read(12'h06C, d, e);
      check("R4 w1c all ones", d, 32'h0);
      model[27] = 32'h0;
      // R5: zero write cannot clear
      apb_write(12'h070, 32'h0, 4'hF, e);
      apb_read(12'h070, d, e);
      check("R5 w1s zero write", d, model[28]);

      // R2: out-of-range offsets
      for (int k = 0; k < 4; k++) begin
         logic [11:0] a;
         a = (k == 0) ? 12'h148 : (k == 1) ? 12'h200 : (k == 2) ? 12'h7F0 : 12'hFFC;
         apb_write(a, 32'hFFFF_FFFF, 4'hF, e);
         check("R2 oor write pslverr", 32'(e), 32'h1);
         apb_read(a, d, e);
         check("R2 oor read zero", d, 32'h0);
         check("R2 oor read pslverr", 32'(e), 32'h1);
      end
      sweep_readback("R2 oor write ignored");

      // R11: partial strobes
      for (int s = 0; s < 15; s++) begin
         apb_write(12'h010, 32'h1234_5678, 4'(s), e);
         check("R11 partial strobe pslverr", 32'(e), 32'h0);
      end
      apb_read(12'h010, d, e);
      check("R11 partial strobe dropped", d, model[4]);

      // R1: misaligned
      apb_write(12'h011, 32'h0BAD_0BAD, 4'hF, e);
      check("R1 misaligned write pslverr", 32'(e), 32'h1);
      apb_read(12'h010, d, e);
      check("R1 misaligned write dropped", d, model[4]);
      apb_read(12'h03E, d, e);
      check("R1 misaligned read data", d, model[15]);
      check("R1 misaligned read pslverr", 32'(e), 32'h1);

      // R9 R10: every size input
      for (int l = 0; l < 32; l++) begin
         strap_pwron = 32'h0100_0000 * 32'(l) + 32'h55;
         cfg_mod_disable = 32'h1 << l;
         do_reset(5'(l));
         apb_read(12'h09C, d, e);
         check("R9/R10 memcfg reset", d, rst_of(39, 5'(l)));
         check("R10 config_error", 32'(config_error), (l >= 27 && l <= 31) ? 32'h0 : 32'h1);
         apb_read(12'h004, d, e);
         check("R8 strap reset", d, strap_pwron);
         apb_read(12'h07C, d, e);
         check("R8 module-disable reset", d, cfg_mod_disable);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule